// File: doc/BRIEF.md
# Software-Loaded TLB Register Front End

This block sits between a processor's support-register port and the entry arrays of a software-loaded, set-associative translation buffer. Support registers are grouped in four banks of sixteen 32-bit registers, and the bank in use is chosen by a 2-bit `bank_sel` input. Banks 0 and 3 are plain storage. Banks 1 and 2 each own a private entry array of 4 sets by 16 entries. Each entry is a pair of 32-bit words, called the tag word and the data word.

Within a TLB bank, software works through a fixed set of registers. It first writes the entry pointer (register 4). It then writes the tag staging register (register 6), which also copies the value into the cause register (register 12). A write to the data register (register 5) then commits the entry. The committed data word is the value just written, and the tag word is taken from the cause register. If the entry being replaced was valid, the block emits a one-cycle flush request that carries that entry's old virtual page address. A read in a TLB bank first copies the addressed entry into registers 5 and 6, so reading either of them returns the entry's contents.

Each request is decoded into one of six operations. These are decoded operations and not a stored state. OP_IDLE does nothing. OP_PLAIN_WR is an ordinary register write. OP_HI_WR is a tag write with the cause side effect. OP_LO_COMMIT is a data write that commits an entry. OP_PLAIN_RD is a read in bank 0 or 3. OP_MIRROR_RD is a read in bank 1 or 2 that refreshes the mirrors. A cycle with `wr_en` goes to a write operation. A cycle with only `rd_en` goes to a read operation, and any other cycle goes to OP_IDLE.

Top module: `tlbp_top`

## Requirements
- R1: After reset, `rd_data`, `flush_req` and `flush_va` are 0, and every support register and every entry word reads as 0.
- R2: In banks 0 and 3, every register index 0 to 15 stores the written value and a later read returns it. Writes to indices 5 and 6 there leave register 12 unchanged, commit no entry and raise no flush.
- R3: In banks 1 and 2, a write to index 6 stores the value in both register 6 and register 12 of that bank.
- R4: The entry pointer is register 4 of the active bank. Bits 5:4 select the set and bits 3:0 select the entry. Bits 31:6 are ignored.
- R5: In banks 1 and 2, a write to index 5 commits the pointed entry. Its data word becomes the written value and its tag word becomes the bank's current register 12.
- R6: If the replaced entry's data word has bit 3 set, `flush_req` is high in the cycle after the commit edge, for that cycle only. In that cycle `flush_va` equals the old tag word's bits 31:13 with bits 12:0 cleared. `flush_va` keeps its value between flushes.
- R7: If the replaced entry's data word has bit 3 clear, the commit raises no flush.
- R8: A read in bank 1 or 2 copies the pointed entry's data word into register 5 and its tag word into register 6 before returning the requested register. As a result, a read of index 6 returns the entry's tag word even after a later write to index 6.
- R9: Bank 1 and bank 2 use separate entry arrays, so a commit through one bank never changes entries seen through the other.
- R10: `rd_data` takes the read result one cycle after `rd_en` and otherwise holds its value. A read requested in the same cycle as a write is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bank_sel | input | 2 | Active support-register bank |
| wr_en | input | 1 | Register write request |
| wr_idx | input | 4 | Register index for the write |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Register read request |
| rd_idx | input | 4 | Register index for the read |
| rd_data | output | 32 | Read result, registered |
| flush_req | output | 1 | One-cycle page flush request |
| flush_va | output | 32 | Page address of the flushed entry |

## Verification
The assertions assume that `bank_sel`, the enables and the indices are driven to known values in every cycle after reset. They also assume that a cause-register check only matters while `bank_sel` stays on the bank that was written. The bench drives all inputs away from the clock edge and always from defined values. A random phase draws banks, indices and data freely, including simultaneous read and write requests and bank changes between cycles, and a behavioural model built on plain arrays predicts every output. Directed phases cover the entry-pointer fields, valid and invalid replacement, back-to-back flushing commits, mirror overwrite and the separation between the two banks.

// File: rtl/tlbp_pkg.sv
package tlbp_pkg;
    localparam int unsigned REG_IDX_W = 4;
    localparam int unsigned BANK_W    = 2;

    localparam logic [REG_IDX_W-1:0] IDX_PTR   = 4'd4;
    localparam logic [REG_IDX_W-1:0] IDX_DATA  = 4'd5;
    localparam logic [REG_IDX_W-1:0] IDX_TAG   = 4'd6;
    localparam logic [REG_IDX_W-1:0] IDX_CAUSE = 4'd12;

    typedef enum logic [2:0] {
        OP_IDLE,
        OP_PLAIN_WR,
        OP_HI_WR,
        OP_LO_COMMIT,
        OP_PLAIN_RD,
        OP_MIRROR_RD
    } op_e;
endpackage

// File: rtl/tlbp_decode.sv
module tlbp_decode
    import tlbp_pkg::*;
(
    input  logic [BANK_W-1:0]    bank_sel,
    input  logic                 wr_en,
    input  logic [REG_IDX_W-1:0] wr_idx,
    input  logic                 rd_en,
    output op_e                  op
);
    logic tlb_bank;

    always_comb begin
        tlb_bank = (bank_sel == 2'd1) || (bank_sel == 2'd2);
        if (wr_en) begin
            if (tlb_bank && wr_idx == IDX_TAG)
                op = OP_HI_WR;
            else if (tlb_bank && wr_idx == IDX_DATA)
                op = OP_LO_COMMIT;
            else
                op = OP_PLAIN_WR;
        end else if (rd_en) begin
            op = tlb_bank ? OP_MIRROR_RD : OP_PLAIN_RD;
        end else begin
            op = OP_IDLE;
        end
    end
endmodule

// File: rtl/tlbp_sreg_file.sv
module tlbp_sreg_file
    import tlbp_pkg::*;
#(
    parameter int unsigned DW     = 32,
    parameter int unsigned NBANKS = 4,
    parameter int unsigned NREGS  = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  op_e                  op,
    input  logic [BANK_W-1:0]    bank_sel,
    input  logic [REG_IDX_W-1:0] wr_idx,
    input  logic [DW-1:0]        wr_data,
    input  logic [REG_IDX_W-1:0] rd_idx,
    input  logic [DW-1:0]        ent_tag,
    input  logic [DW-1:0]        ent_data,
    output logic [DW-1:0]        ptr_q,
    output logic [DW-1:0]        cause_q,
    output logic [DW-1:0]        rd_val
);
    logic [DW-1:0] regs [NBANKS][NREGS];

    assign ptr_q   = regs[bank_sel][IDX_PTR];
    assign cause_q = regs[bank_sel][IDX_CAUSE];
    assign rd_val  = regs[bank_sel][rd_idx];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int b = 0; b < NBANKS; b++)
                for (int r = 0; r < NREGS; r++)
                    regs[b][r] <= '0;
        end else begin
            unique case (op)
                OP_PLAIN_WR, OP_LO_COMMIT: begin
                    regs[bank_sel][wr_idx] <= wr_data;
                end
                OP_HI_WR: begin
                    regs[bank_sel][wr_idx]    <= wr_data;
                    regs[bank_sel][IDX_CAUSE] <= wr_data;
                end
                OP_MIRROR_RD: begin
                    regs[bank_sel][IDX_DATA] <= ent_data;
                    regs[bank_sel][IDX_TAG]  <= ent_tag;
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/tlbp_entry_array.sv
module tlbp_entry_array #(
    parameter int unsigned DW      = 32,
    parameter int unsigned ADDR_W  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DW-1:0]     tag_in,
    input  logic [DW-1:0]     data_in,
    output logic [DW-1:0]     tag_out,
    output logic [DW-1:0]     data_out
);
    localparam int unsigned DEPTH = 1 << ADDR_W;

    logic [DW-1:0] tag_mem  [DEPTH];
    logic [DW-1:0] data_mem [DEPTH];

    assign tag_out  = tag_mem[addr];
    assign data_out = data_mem[addr];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                tag_mem[i]  <= '0;
                data_mem[i] <= '0;
            end
        end else if (we) begin
            tag_mem[addr]  <= tag_in;
            data_mem[addr] <= data_in;
        end
    end
endmodule

// File: rtl/tlbp_top.sv
module tlbp_top
    import tlbp_pkg::*;
#(
    parameter int unsigned DW         = 32,
    parameter int unsigned SETS       = 4,
    parameter int unsigned ENTRIES    = 16,
    parameter int unsigned PAGE_SHIFT = 13,
    parameter int unsigned VALID_BIT  = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    bank_sel,
    input  logic          wr_en,
    input  logic [3:0]    wr_idx,
    input  logic [31:0]   wr_data,
    input  logic          rd_en,
    input  logic [3:0]    rd_idx,
    output logic [31:0]   rd_data,
    output logic          flush_req,
    output logic [31:0]   flush_va
);
    localparam int unsigned SET_W   = $clog2(SETS);
    localparam int unsigned ENT_W   = $clog2(ENTRIES);
    localparam int unsigned ADDR_W  = SET_W + ENT_W;
    localparam int unsigned N_ARRAY = 2;

    op_e              op;
    logic [DW-1:0]    ptr_q;
    logic [DW-1:0]    cause_q;
    logic [DW-1:0]    sreg_rd;
    logic [DW-1:0]    old_tag;
    logic [DW-1:0]    old_lo;
    logic [ADDR_W-1:0] ent_addr;
    logic [DW-1:0]    arr_tag  [N_ARRAY];
    logic [DW-1:0]    arr_data [N_ARRAY];

    // set field sits directly above the entry field in the pointer
    assign ent_addr = {ptr_q[ENT_W +: SET_W], ptr_q[0 +: ENT_W]};

    tlbp_decode u_decode (
        .bank_sel (bank_sel),
        .wr_en    (wr_en),
        .wr_idx   (wr_idx),
        .rd_en    (rd_en),
        .op       (op)
    );

    tlbp_sreg_file #(.DW(DW)) u_sregs (
        .clk      (clk),
        .rst_n    (rst_n),
        .op       (op),
        .bank_sel (bank_sel),
        .wr_idx   (wr_idx),
        .wr_data  (wr_data),
        .rd_idx   (rd_idx),
        .ent_tag  (old_tag),
        .ent_data (old_lo),
        .ptr_q    (ptr_q),
        .cause_q  (cause_q),
        .rd_val   (sreg_rd)
    );

    for (genvar g = 0; g < N_ARRAY; g++) begin : g_array
        logic arr_we;
        assign arr_we = (op == OP_LO_COMMIT) && (bank_sel == BANK_W'(g + 1));

        tlbp_entry_array #(.DW(DW), .ADDR_W(ADDR_W)) u_array (
            .clk      (clk),
            .rst_n    (rst_n),
            .we       (arr_we),
            .addr     (ent_addr),
            .tag_in   (cause_q),
            .data_in  (wr_data),
            .tag_out  (arr_tag[g]),
            .data_out (arr_data[g])
        );
    end

    assign old_tag = (bank_sel == 2'd2) ? arr_tag[1]  : arr_tag[0];
    assign old_lo  = (bank_sel == 2'd2) ? arr_data[1] : arr_data[0];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data   <= '0;
            flush_req <= 1'b0;
            flush_va  <= '0;
        end else begin
            flush_req <= 1'b0;
            unique case (op)
                OP_LO_COMMIT: begin
                    if (old_lo[VALID_BIT]) begin
                        flush_req <= 1'b1;
                        flush_va  <= {old_tag[DW-1:PAGE_SHIFT], {PAGE_SHIFT{1'b0}}};
                    end
                end
                OP_PLAIN_RD: rd_data <= sreg_rd;
                OP_MIRROR_RD: begin
                    if (rd_idx == IDX_DATA)
                        rd_data <= old_lo;
                    else if (rd_idx == IDX_TAG)
                        rd_data <= old_tag;
                    else
                        rd_data <= sreg_rd;
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/tlbp_checker.sv
module tlbp_checker (
    input logic        clk,
    input logic        rst_n,
    input logic [1:0]  bank_sel,
    input logic        wr_en,
    input logic [3:0]  wr_idx,
    input logic [31:0] wr_data,
    input logic        rd_en,
    input logic [31:0] rd_data,
    input logic        flush_req,
    input logic [31:0] flush_va,
    input logic [31:0] cause_q,
    input logic [31:0] old_lo
);
    logic tlb_bank;
    logic commit;
    assign tlb_bank = (bank_sel == 2'd1) || (bank_sel == 2'd2);
    assign commit   = wr_en && tlb_bank && (wr_idx == 4'd5);

    assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !flush_req && rd_data == 32'd0);

    assert_plain_no_flush_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !tlb_bank) |=> !flush_req);

    assert_cause_follow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && tlb_bank && wr_idx == 4'd6) |=>
            (bank_sel != $past(bank_sel) || cause_q == $past(wr_data)));

    assert_flush_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
        flush_req |-> $past(commit));

    assert_flush_aligned_R6: assert property (@(posedge clk) disable iff (!rst_n)
        flush_req |-> flush_va[12:0] == 13'd0);

    assert_no_flush_invalid_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && !old_lo[3]) |=> !flush_req);

    assert_rd_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_en || wr_en) |=> $stable(rd_data));
endmodule

bind tlbp_top tlbp_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bank_sel  (bank_sel),
    .wr_en     (wr_en),
    .wr_idx    (wr_idx),
    .wr_data   (wr_data),
    .rd_en     (rd_en),
    .rd_data   (rd_data),
    .flush_req (flush_req),
    .flush_va  (flush_va),
    .cause_q   (cause_q),
    .old_lo    (old_lo)
);

// File: tb/tlbp_top_bench.sv
`timescale 1ns/1ps
module tlbp_top_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  bank_sel = '0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_idx = '0;
    logic [31:0] wr_data = '0;
    logic        rd_en = 1'b0;
    logic [3:0]  rd_idx = '0;
    logic [31:0] rd_data;
    logic        flush_req;
    logic [31:0] flush_va;

    int n_chk = 0;
    int n_fail = 0;
    string cur_req = "R1";

    // behavioural model
    logic [31:0] m_reg  [4][16];
    logic [31:0] m_tag  [2][64];
    logic [31:0] m_data [2][64];
    logic [31:0] exp_rd = '0;
    logic        exp_fl = 1'b0;
    logic [31:0] exp_va = '0;

    always #2.5 clk = ~clk;

    tlbp_top u_tlbp_top (
        .clk(clk), .rst_n(rst_n), .bank_sel(bank_sel),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .rd_en(rd_en), .rd_idx(rd_idx), .rd_data(rd_data),
        .flush_req(flush_req), .flush_va(flush_va)
    );

    task automatic check(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", cur_req, what, act, exp);
        end
    endtask

    task automatic compare_all();
        check(rd_data === exp_rd, "rd_data", rd_data, exp_rd);
        check(flush_req === exp_fl, "flush_req", {31'd0, flush_req}, {31'd0, exp_fl});
        check(flush_va === exp_va, "flush_va", flush_va, exp_va);
    endtask

    task automatic step(input bit w, input logic [1:0] b, input logic [3:0] wi,
                        input logic [31:0] wd, input bit r, input logic [3:0] ri);
        bit tb;
        int k;
        int a;
        wr_en = w; bank_sel = b; wr_idx = wi; wr_data = wd; rd_en = r; rd_idx = ri;
        tb = (b == 2'd1) || (b == 2'd2);
        k = int'(b) - 1;
        a = int'(m_reg[b][4][5:0]);
        exp_fl = 1'b0;
        if (w) begin
            if (tb && wi == 4'd5) begin
                if (m_data[k][a][3]) begin
                    exp_fl = 1'b1;
                    exp_va = {m_tag[k][a][31:13], 13'd0};
                end
                m_tag[k][a]  = m_reg[b][12];
                m_data[k][a] = wd;
            end
            m_reg[b][wi] = wd;
            if (tb && wi == 4'd6) m_reg[b][12] = wd;
        end else if (r) begin
            if (tb) begin
                m_reg[b][5] = m_data[k][a];
                m_reg[b][6] = m_tag[k][a];
            end
            exp_rd = m_reg[b][ri];
        end
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0;
        compare_all();
    endtask

    task automatic wr(input logic [1:0] b, input logic [3:0] i, input logic [31:0] d);
        step(1'b1, b, i, d, 1'b0, 4'd0);
    endtask

    task automatic rd(input logic [1:0] b, input logic [3:0] i);
        step(1'b0, b, 4'd0, 32'd0, 1'b1, i);
    endtask

    initial begin
        #1000000;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        for (int b = 0; b < 4; b++)
            for (int r = 0; r < 16; r++) m_reg[b][r] = '0;
        for (int k = 0; k < 2; k++)
            for (int a = 0; a < 64; a++) begin m_tag[k][a] = '0; m_data[k][a] = '0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        cur_req = "R1"; compare_all();
        rd(2'd1, 4'd6); rd(2'd0, 4'd3); rd(2'd2, 4'd12);

        // pointer fields and commit
        cur_req = "R4"; wr(2'd1, 4'd4, 32'hFFFF_FF25);
        cur_req = "R3"; wr(2'd1, 4'd6, 32'hABCD_FFFF); rd(2'd1, 4'd12);
        cur_req = "R7"; wr(2'd1, 4'd5, 32'h0000_0008);
        cur_req = "R5"; rd(2'd1, 4'd6); rd(2'd1, 4'd5);
        cur_req = "R6"; wr(2'd1, 4'd6, 32'h1234_5000); wr(2'd1, 4'd5, 32'h0000_0009);
        wr(2'd1, 4'd5, 32'h0000_0000);
        cur_req = "R7"; wr(2'd1, 4'd5, 32'h0000_0008);
        cur_req = "R8"; wr(2'd1, 4'd6, 32'h0000_0055); rd(2'd1, 4'd6); rd(2'd1, 4'd12);
        cur_req = "R4"; wr(2'd1, 4'd4, 32'h0000_000F); rd(2'd1, 4'd5);
        wr(2'd1, 4'd4, 32'h0000_0035); rd(2'd1, 4'd6);

        // bank separation
        cur_req = "R9"; wr(2'd2, 4'd4, 32'h0000_0025); rd(2'd2, 4'd6);
        wr(2'd2, 4'd6, 32'hDEAD_B000); wr(2'd2, 4'd5, 32'h8); wr(2'd2, 4'd5, 32'h8);
        wr(2'd1, 4'd4, 32'h25); rd(2'd1, 4'd6); rd(2'd2, 4'd6);

        // plain banks
        cur_req = "R2";
        for (int b = 0; b < 4; b += 3) begin
            wr(2'(b), 4'd4, 32'h25); wr(2'(b), 4'd6, 32'h7777_7000);
            wr(2'(b), 4'd5, 32'h0000_000F); wr(2'(b), 4'd5, 32'h0000_000F);
            rd(2'(b), 4'd5); rd(2'(b), 4'd6); rd(2'(b), 4'd12);
        end
        rd(2'd1, 4'd6);

        // read ignored alongside write
        cur_req = "R10"; rd(2'd0, 4'd5);
        step(1'b1, 2'd0, 4'd3, 32'h3333_3333, 1'b1, 4'd3);
        step(1'b0, 2'd0, 4'd0, 32'd0, 1'b0, 4'd3);

        // random traffic
        cur_req = "R5";
        for (int n = 0; n < 3000; n++) begin
            logic [3:0] i;
            logic [31:0] d;
            i = ($urandom % 3 == 0) ? 4'($urandom) : 4'(4 + $urandom % 3);
            d = $urandom;
            if (i == 4'd4) d = d & 32'h3F;
            step(1'($urandom), 2'($urandom), i, d, 1'($urandom), 4'(4 + $urandom % 3));
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule